// File: doc/BRIEF.md
# Trigger crate initialization sequencer

This controller brings the modules of a trigger crate into a known state by walking a fixed, ordered list of register writes over a simple request/acknowledge register bus. A pulse on `start_i` latches a small descriptor: how many prescaler units and how many delay-width-fanout units are fitted, and which of the four trigger groups should end up enabled. The block then issues every write in turn. After each write to a readable register it issues a read of the same location and compares the returned word. A single-cycle `done_o` pulse marks the end of the sequence.

Triggers stay inhibited for the whole walk. The trigger-group enable register is zeroed first and gets its final mask only near the end. The sequencer module is configured a second time, and its clear is raised and then dropped, before the groups are enabled. The output module is write-only, so it is never read back. It is zeroed second and written with its final value as the very last step. A read-back mismatch halts the walk and latches the step code. Write values come from a parameter table. Loop writes add the flat channel index to a per-kind base value.

Top module: `tcrate_init_ctrl`

## Requirements
- R1: The first write after a start is to module code 0 (sequencer) at address 0 (group enable) with data 0, which inhibits all trigger groups.
- R2: The second write is to module code 1 (write-only output module), address 0, data 0. No read is ever issued to module code 1.
- R3: For each prescaler unit u from 0 to n_psc-1, and each channel c from 0 to 3 in that order, there is one write to module code 2, address 0, with data = table entry 1 + 4u + c.
- R4: For each fanout unit u from 0 to n_dwf-1, and each channel c from 0 to 5 in that order, there is one write to module code 3, address 0, with data = table entry 2 + 6u + c.
- R5: The channel loops are followed by writes to module code 4 (transmitter) at addresses 0, 1 and 2 with table entries 3, 4 and 5. Then comes a write to module code 5 (association), address 0, with table entry 6.
- R6: The sequencer is then written at address 1 with table entry 0. Next comes address 2 with data 1, then address 2 with data 0, then address 0 with the 4-bit group mask latched at start.
- R7: The last write is to module code 1, address 0, with table entry 7. `done_o` is high for exactly the one cycle after that write is acknowledged.
- R8: Every write to a module other than code 1 is followed immediately by a read with the same module, unit, channel and address. If the returned word differs from the written one, requests stop, `busy_o` falls, and `err_o` stays set with `err_step_o` holding the step code until the next start. Step codes: 0 inhibit, 1 output zero, 2 prescaler, 3 fanout, 4/5/6 transmitter, 7 association, 8 sequencer config, 9 clear set, 10 clear release, 11 group enable, 12 output final.
- R9: A unit count of zero skips the matching channel loop entirely.
- R10: While a request is not acknowledged, `bus_valid_o` stays high and every request field stays unchanged.
- R11: The group-enable register receives no non-zero value before the group-enable step of R6.
- R12: After reset `busy_o`, `done_o`, `err_o` and `bus_valid_o` are low. A start pulse while busy has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a setup walk (taken only when idle) |
| n_psc_i | input | UNIT_W | Number of prescaler units fitted |
| n_dwf_i | input | UNIT_W | Number of fanout units fitted |
| grp_mask_i | input | NGRP | Final trigger-group enable mask |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read-back mismatch seen |
| err_step_o | output | 4 | Step code of the failing check |
| bus_valid_o | output | 1 | Request present |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_mod_o | output | 3 | Target module code |
| bus_unit_o | output | UNIT_W | Unit index within a module kind |
| bus_chan_o | output | CH_W | Channel within the unit |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DW | Write data |
| bus_ready_i | input | 1 | Request accepted this cycle |
| bus_rdata_i | input | DW | Read data, valid in the cycle a read is accepted |

## Verification
The assertions assume that the bus returns read data in the same cycle that it accepts a read. They also assume that `bus_ready_i` may be low for any number of cycles without the request being withdrawn. The descriptor inputs matter only in the start cycle. The bench slave meets these assumptions by changing `bus_ready_i` and `bus_rdata_i` only after the outputs have settled, which gives the data in the accepting cycle. It stalls with three different ready patterns and pulses start mid-walk, so the hold and inhibit properties are exercised under back-pressure.

// File: rtl/tci_pkg.sv
`timescale 1ns/1ps
// tci_pkg: shared codes for the crate setup walker.
// Assumes module codes and step codes are fixed by the crate bus map.
package tci_pkg;

    typedef enum logic [2:0] {
        MOD_SEQ = 3'd0,
        MOD_OUT = 3'd1,
        MOD_PSC = 3'd2,
        MOD_DWF = 3'd3,
        MOD_TX  = 3'd4,
        MOD_AO  = 3'd5
    } tci_mod_e;

    typedef enum logic [3:0] {
        PH_INHIBIT  = 4'd0,
        PH_OUT_ZERO = 4'd1,
        PH_PSC      = 4'd2,
        PH_DWF      = 4'd3,
        PH_TX_HEX   = 4'd4,
        PH_TX_RR1   = 4'd5,
        PH_TX_RR2   = 4'd6,
        PH_AO       = 4'd7,
        PH_SEQ_CFG  = 4'd8,
        PH_CLR_SET  = 4'd9,
        PH_CLR_REL  = 4'd10,
        PH_GRP_EN   = 4'd11,
        PH_OUT_LAST = 4'd12
    } tci_phase_e;

    // Table slots for write data.
    localparam int TBL_SEQ_CFG = 0;
    localparam int TBL_PSC     = 1;
    localparam int TBL_DWF     = 2;
    localparam int TBL_TX_HEX  = 3;
    localparam int TBL_TX_RR1  = 4;
    localparam int TBL_TX_RR2  = 5;
    localparam int TBL_AO      = 6;
    localparam int TBL_OUT     = 7;
    localparam int TBL_ENTRIES = 8;

    // Sequencer register addresses.
    localparam int SEQ_A_ENABLE = 0;
    localparam int SEQ_A_CFG    = 1;
    localparam int SEQ_A_CLEAR  = 2;

endpackage

// File: rtl/tci_walker.sv
`timescale 1ns/1ps
// tci_walker: holds the current step position (phase, unit, channel)
// and moves it forward one write at a time. Empty channel loops are skipped.
// Assumes adv_i is never raised on the final phase, and not in the load cycle.
module tci_walker
    import tci_pkg::*;
#(
    parameter int UNIT_W = 3,
    parameter int CH_W   = 3,
    parameter int PSC_CH = 4,
    parameter int DWF_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [UNIT_W-1:0] n_psc_i,
    input  logic [UNIT_W-1:0] n_dwf_i,
    output tci_phase_e        phase_o,
    output logic [UNIT_W-1:0] unit_o,
    output logic [CH_W-1:0]   chan_o
);

    localparam logic [CH_W-1:0] PSC_LAST = CH_W'(PSC_CH - 1);
    localparam logic [CH_W-1:0] DWF_LAST = CH_W'(DWF_CH - 1);

    tci_phase_e        phase_q, ph_next;
    logic [UNIT_W-1:0] unit_q, npsc_q, ndwf_q;
    logic [CH_W-1:0]   chan_q;
    logic              in_loop, ch_last, unit_last;

    // Next phase in the list, stepping over loops whose count is zero.
    always_comb begin
        ph_next = tci_phase_e'(phase_q + 4'd1);
        if (ph_next == PH_PSC && npsc_q == '0) ph_next = PH_DWF;
        if (ph_next == PH_DWF && ndwf_q == '0) ph_next = PH_TX_HEX;
    end

    // Loop position flags for the two per-channel phases.
    always_comb begin
        in_loop   = (phase_q == PH_PSC) || (phase_q == PH_DWF);
        ch_last   = (phase_q == PH_PSC) ? (chan_q == PSC_LAST) : (chan_q == DWF_LAST);
        unit_last = (phase_q == PH_PSC) ? (unit_q == npsc_q - 1'b1)
                                        : (unit_q == ndwf_q - 1'b1);
    end

    // Position register: channel, then unit, then phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_INHIBIT;
            unit_q  <= '0;
            chan_q  <= '0;
            npsc_q  <= '0;
            ndwf_q  <= '0;
        end else if (load_i) begin
            phase_q <= PH_INHIBIT;
            unit_q  <= '0;
            chan_q  <= '0;
            npsc_q  <= n_psc_i;
            ndwf_q  <= n_dwf_i;
        end else if (adv_i) begin
            if (in_loop && !ch_last) begin
                chan_q <= chan_q + 1'b1;
            end else if (in_loop && !unit_last) begin
                chan_q <= '0;
                unit_q <= unit_q + 1'b1;
            end else begin
                chan_q  <= '0;
                unit_q  <= '0;
                phase_q <= ph_next;
            end
        end
    end

    assign phase_o = phase_q;
    assign unit_o  = unit_q;
    assign chan_o  = chan_q;

    // A prescaler step only exists for a fitted unit (R3, R9).
    assert_psc_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PSC) |-> (unit_q < npsc_q && chan_q <= PSC_LAST));
    // A fanout step only exists for a fitted unit (R4, R9).
    assert_dwf_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DWF) |-> (unit_q < ndwf_q && chan_q <= DWF_LAST));

endmodule

// File: rtl/tci_step_decode.sv
`timescale 1ns/1ps
// tci_step_decode: maps a step position to the bus request it issues:
// module, address, write data, and whether a read-back follows.
// Purely combinational; assumes the table holds one word per slot.
module tci_step_decode
    import tci_pkg::*;
#(
    parameter int DW     = 32,
    parameter int UNIT_W = 3,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4,
    parameter int NGRP   = 4,
    parameter int PSC_CH = 4,
    parameter int DWF_CH = 6,
    parameter logic [TBL_ENTRIES-1:0][DW-1:0] INIT_TABLE = '0
) (
    input  tci_phase_e        phase_i,
    input  logic [UNIT_W-1:0] unit_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [NGRP-1:0]   mask_i,
    output tci_mod_e          mod_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DW-1:0]     data_o,
    output logic              rb_o,
    output logic              last_o
);

    localparam logic [DW-1:0] PSC_STRIDE = DW'(PSC_CH);
    localparam logic [DW-1:0] DWF_STRIDE = DW'(DWF_CH);

    logic [DW-1:0] psc_off, dwf_off;

    // Flat channel offsets for the two loop kinds.
    always_comb begin
        psc_off = DW'(unit_i) * PSC_STRIDE + DW'(chan_i);
        dwf_off = DW'(unit_i) * DWF_STRIDE + DW'(chan_i);
    end

    // Request fields per phase.
    always_comb begin
        mod_o  = MOD_SEQ;
        addr_o = '0;
        data_o = '0;
        case (phase_i)
            PH_INHIBIT:  begin mod_o = MOD_SEQ; addr_o = ADDR_W'(SEQ_A_ENABLE); data_o = '0; end
            PH_OUT_ZERO: begin mod_o = MOD_OUT; data_o = '0; end
            PH_PSC:      begin mod_o = MOD_PSC; data_o = INIT_TABLE[TBL_PSC] + psc_off; end
            PH_DWF:      begin mod_o = MOD_DWF; data_o = INIT_TABLE[TBL_DWF] + dwf_off; end
            PH_TX_HEX:   begin mod_o = MOD_TX;  addr_o = ADDR_W'(0); data_o = INIT_TABLE[TBL_TX_HEX]; end
            PH_TX_RR1:   begin mod_o = MOD_TX;  addr_o = ADDR_W'(1); data_o = INIT_TABLE[TBL_TX_RR1]; end
            PH_TX_RR2:   begin mod_o = MOD_TX;  addr_o = ADDR_W'(2); data_o = INIT_TABLE[TBL_TX_RR2]; end
            PH_AO:       begin mod_o = MOD_AO;  data_o = INIT_TABLE[TBL_AO]; end
            PH_SEQ_CFG:  begin mod_o = MOD_SEQ; addr_o = ADDR_W'(SEQ_A_CFG); data_o = INIT_TABLE[TBL_SEQ_CFG]; end
            PH_CLR_SET:  begin mod_o = MOD_SEQ; addr_o = ADDR_W'(SEQ_A_CLEAR); data_o = DW'(1); end
            PH_CLR_REL:  begin mod_o = MOD_SEQ; addr_o = ADDR_W'(SEQ_A_CLEAR); data_o = '0; end
            PH_GRP_EN:   begin mod_o = MOD_SEQ; addr_o = ADDR_W'(SEQ_A_ENABLE); data_o = DW'(mask_i); end
            PH_OUT_LAST: begin mod_o = MOD_OUT; data_o = INIT_TABLE[TBL_OUT]; end
            default:     begin mod_o = MOD_SEQ; end
        endcase
    end

    // The write-only module is never read back; its final write ends the list.
    always_comb begin
        rb_o   = (mod_o != MOD_OUT);
        last_o = (phase_i == PH_OUT_LAST);
    end

endmodule

// File: rtl/tcrate_init_ctrl.sv
`timescale 1ns/1ps
// tcrate_init_ctrl: top of the crate setup walker. Takes a start pulse,
// latches the descriptor, and runs write / read-back transactions over the
// register bus until the list ends or a read-back mismatches.
// Assumes read data is valid in the cycle a read is accepted.
module tcrate_init_ctrl
    import tci_pkg::*;
#(
    parameter int DW     = 32,
    parameter int UNIT_W = 3,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4,
    parameter int NGRP   = 4,
    parameter int PSC_CH = 4,
    parameter int DWF_CH = 6,
    parameter logic [TBL_ENTRIES-1:0][DW-1:0] INIT_TABLE = {
        32'hB0D0_0001, 32'hA0A0_0707, 32'h7272_0002, 32'h7171_0001,
        32'h6E6E_0003, 32'hD000_0100, 32'hC000_0200, 32'h5E0C_0F61}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [UNIT_W-1:0] n_psc_i,
    input  logic [UNIT_W-1:0] n_dwf_i,
    input  logic [NGRP-1:0]   grp_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [3:0]        err_step_o,
    output logic              bus_valid_o,
    output logic              bus_write_o,
    output logic [2:0]        bus_mod_o,
    output logic [UNIT_W-1:0] bus_unit_o,
    output logic [CH_W-1:0]   bus_chan_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DW-1:0]     bus_wdata_o,
    input  logic              bus_ready_i,
    input  logic [DW-1:0]     bus_rdata_i
);

    typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_e;

    st_e               state_q;
    logic [NGRP-1:0]   mask_q;
    logic              done_q, err_q;
    logic [3:0]        err_step_q;
    logic              load, adv, rb, last, rd_ok;
    tci_phase_e        phase;
    tci_mod_e          mod;
    logic [UNIT_W-1:0] unit;
    logic [CH_W-1:0]   chan;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]     wdata;

    tci_walker #(
        .UNIT_W(UNIT_W), .CH_W(CH_W), .PSC_CH(PSC_CH), .DWF_CH(DWF_CH)
    ) walk_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
        .n_psc_i(n_psc_i), .n_dwf_i(n_dwf_i),
        .phase_o(phase), .unit_o(unit), .chan_o(chan)
    );

    tci_step_decode #(
        .DW(DW), .UNIT_W(UNIT_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .NGRP(NGRP),
        .PSC_CH(PSC_CH), .DWF_CH(DWF_CH), .INIT_TABLE(INIT_TABLE)
    ) dec_i (
        .phase_i(phase), .unit_i(unit), .chan_i(chan), .mask_i(mask_q),
        .mod_o(mod), .addr_o(addr), .data_o(wdata), .rb_o(rb), .last_o(last)
    );

    // Walker control: load on accepted start, advance after each finished step.
    always_comb begin
        rd_ok = (bus_rdata_i == wdata);
        load  = (state_q == S_IDLE) && start_i;
        adv   = ((state_q == S_WR) && bus_ready_i && !rb && !last) ||
                ((state_q == S_RD) && bus_ready_i && rd_ok);
    end

    // Transaction state, completion pulse and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mask_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_step_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    state_q <= S_WR;
                    err_q   <= 1'b0;
                    mask_q  <= grp_mask_i;
                end
                S_WR: if (bus_ready_i) begin
                    if (rb) begin
                        state_q <= S_RD;
                    end else if (last) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                S_RD: if (bus_ready_i) begin
                    if (!rd_ok) begin
                        err_q      <= 1'b1;
                        err_step_q <= phase;
                        state_q    <= S_IDLE;
                    end else begin
                        state_q <= S_WR;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Bus and status outputs.
    always_comb begin
        bus_valid_o = (state_q != S_IDLE);
        bus_write_o = (state_q == S_WR);
        bus_mod_o   = mod;
        bus_unit_o  = unit;
        bus_chan_o  = chan;
        bus_addr_o  = addr;
        bus_wdata_o = wdata;
        busy_o      = (state_q != S_IDLE);
        done_o      = done_q;
        err_o       = err_q;
        err_step_o  = err_step_q;
    end

    // Request held unchanged while not accepted (R10).
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_write_o) &&
        $stable(bus_mod_o) && $stable(bus_unit_o) && $stable(bus_chan_o) &&
        $stable(bus_addr_o) && $stable(bus_wdata_o)));

    // Accepted readable write is followed by a read of the same place (R8).
    assert_rb_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_ready_i && bus_write_o && bus_mod_o != 3'(MOD_OUT)) |=>
        (bus_valid_o && !bus_write_o && $stable(bus_mod_o) && $stable(bus_unit_o) &&
         $stable(bus_chan_o) && $stable(bus_addr_o)));

    // Write-only module is never read (R2).
    assert_no_out_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_write_o) |-> (bus_mod_o != 3'(MOD_OUT)));

    // Completion follows an accepted write to the write-only module (R7).
    assert_done_after_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(bus_valid_o && bus_ready_i && bus_write_o &&
                         bus_mod_o == 3'(MOD_OUT)));

    // Completion is a single-cycle pulse (R7).
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Error holds its step code and stops requests until restart (R8).
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> (err_o && $stable(err_step_o) && !bus_valid_o));

    // No trigger group enabled before the group-enable step (R11).
    assert_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_write_o && bus_mod_o == 3'(MOD_SEQ) &&
         bus_addr_o == ADDR_W'(SEQ_A_ENABLE) && bus_wdata_o != '0) |->
        (phase == PH_GRP_EN));

endmodule

// File: tb/tcrate_init_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: table of descriptor/stall vectors walked by one loop, then directed
// reset, read-back error and recovery tests. A bus slave model answers reads.
module tcrate_init_ctrl_tb_top;

    localparam int DW = 32, UNIT_W = 3, CH_W = 3, ADDR_W = 4, NGRP = 4;
    localparam logic [7:0][31:0] TBL = {
        32'h1111_0008, 32'h2222_0007, 32'h3333_0006, 32'h4444_0005,
        32'h5555_0004, 32'h6600_0100, 32'h7700_0200, 32'h8888_0001};

    typedef struct packed {
        logic [2:0] np;
        logic [2:0] nd;
        logic [3:0] mask;
        logic [1:0] rmode;
        logic       mid_start;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{3'd2, 3'd1, 4'b1010, 2'd0, 1'b0},
        '{3'd0, 3'd0, 4'b1111, 2'd1, 1'b0},
        '{3'd1, 3'd0, 4'b0001, 2'd2, 1'b1},
        '{3'd0, 3'd3, 4'b0000, 2'd0, 1'b0},
        '{3'd7, 3'd7, 4'b0110, 2'd1, 1'b0},
        '{3'd3, 3'd2, 4'b1001, 2'd2, 1'b1}};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [UNIT_W-1:0] n_psc = '0, n_dwf = '0;
    logic [NGRP-1:0] mask = '0;
    logic busy, done, err, bvalid, bwrite;
    logic [3:0] err_step;
    logic [2:0] bmod;
    logic [UNIT_W-1:0] bunit;
    logic [CH_W-1:0] bchan;
    logic [ADDR_W-1:0] baddr;
    logic [DW-1:0] bwdata;
    logic bready = 1'b0;
    logic [DW-1:0] brdata = '0;

    tcrate_init_ctrl #(.DW(DW), .UNIT_W(UNIT_W), .CH_W(CH_W), .ADDR_W(ADDR_W),
        .NGRP(NGRP), .INIT_TABLE(TBL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .n_psc_i(n_psc),
        .n_dwf_i(n_dwf), .grp_mask_i(mask), .busy_o(busy), .done_o(done),
        .err_o(err), .err_step_o(err_step), .bus_valid_o(bvalid),
        .bus_write_o(bwrite), .bus_mod_o(bmod), .bus_unit_o(bunit),
        .bus_chan_o(bchan), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
        .bus_ready_i(bready), .bus_rdata_i(brdata));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, rmode = 0, corrupt_idx = -1;
    int rd_cnt = 0, lg_n = 0, done_cnt = 0, done_cyc = -1, out_cyc = -2;
    bit finished = 0;
    logic [DW-1:0] last_wdata = '0;
    logic        lg_wr   [0:255];
    logic [2:0]  lg_mod  [0:255];
    logic [2:0]  lg_unit [0:255];
    logic [2:0]  lg_chan [0:255];
    logic [3:0]  lg_addr [0:255];
    logic [31:0] lg_data [0:255];
    int exp_n = 0;
    logic [2:0]  ex_mod  [0:127];
    logic [2:0]  ex_unit [0:127];
    logic [2:0]  ex_chan [0:127];
    logic [3:0]  ex_addr [0:127];
    logic [31:0] ex_data [0:127];
    string       ex_tag  [0:127];

    // Slave: ready pattern and read data, updated after outputs settle.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        case (rmode)
            0: bready = 1'b1;
            1: bready = cyc[0];
            default: bready = (cyc % 3 == 2);
        endcase
        brdata = last_wdata ^ ((rd_cnt == corrupt_idx) ? 32'h1 : 32'h0);
    end

    // Monitor: log accepted requests and completion pulses.
    always @(negedge clk) begin
        if (bvalid && bready) begin
            if (lg_n < 256) begin
                lg_wr[lg_n] = bwrite; lg_mod[lg_n] = bmod; lg_unit[lg_n] = bunit;
                lg_chan[lg_n] = bchan; lg_addr[lg_n] = baddr; lg_data[lg_n] = bwdata;
            end
            lg_n = lg_n + 1;
            if (bwrite) last_wdata = bwdata; else rd_cnt = rd_cnt + 1;
            if (bwrite && bmod == 3'd1) out_cyc = cyc;
        end
        if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add(input int m, input int u, input int c, input int a,
                       input logic [31:0] d, input string tag);
        ex_mod[exp_n] = 3'(m); ex_unit[exp_n] = 3'(u); ex_chan[exp_n] = 3'(c);
        ex_addr[exp_n] = 4'(a); ex_data[exp_n] = d; ex_tag[exp_n] = tag;
        exp_n = exp_n + 1;
    endtask

    // Expected write list from the requirements.
    task automatic build(input int np, input int nd, input logic [3:0] m);
        exp_n = 0;
        add(0, 0, 0, 0, 32'h0, "R1");
        add(1, 0, 0, 0, 32'h0, "R2");
        for (int u = 0; u < np; u++)
            for (int c = 0; c < 4; c++) add(2, u, c, 0, TBL[1] + 32'(4*u + c), "R3");
        for (int u = 0; u < nd; u++)
            for (int c = 0; c < 6; c++) add(3, u, c, 0, TBL[2] + 32'(6*u + c), "R4");
        add(4, 0, 0, 0, TBL[3], "R5");
        add(4, 0, 0, 1, TBL[4], "R5");
        add(4, 0, 0, 2, TBL[5], "R5");
        add(5, 0, 0, 0, TBL[6], "R5");
        add(0, 0, 0, 1, TBL[0], "R6");
        add(0, 0, 0, 2, 32'h1, "R6");
        add(0, 0, 0, 2, 32'h0, "R6");
        add(0, 0, 0, 0, 32'(m), "R6");
        add(1, 0, 0, 0, TBL[7], "R7");
    endtask

    task automatic launch(input int np, input int nd, input logic [3:0] m,
                          input int rm, input bit mid, input int cidx);
        lg_n = 0; rd_cnt = 0; done_cnt = 0; done_cyc = -1; out_cyc = -2;
        rmode = rm; corrupt_idx = cidx;
        @(negedge clk);
        n_psc = 3'(np); n_dwf = 3'(nd); mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n_psc = 3'd5; n_dwf = 3'd5; mask = 4'b0101;
        if (mid) begin
            repeat (5) @(negedge clk);
            start = 1'b1;  // R12: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
    endtask

    // Compare the logged run against the expected list.
    task automatic check_run(input int np, input int nd);
        int wi = 0, bad_pair = 0, out_rd = 0, en_early = 0;
        for (int i = 0; i < lg_n && i < 256; i++) begin
            if (lg_wr[i]) begin
                if (wi < exp_n)
                    chk(lg_mod[i] == ex_mod[wi] && lg_unit[i] == ex_unit[wi] &&
                        lg_chan[i] == ex_chan[wi] && lg_addr[i] == ex_addr[wi] &&
                        lg_data[i] == ex_data[wi], ex_tag[wi], "write fields",
                        {lg_mod[i], lg_unit[i], lg_chan[i], lg_addr[i], lg_data[i]},
                        {ex_mod[wi], ex_unit[wi], ex_chan[wi], ex_addr[wi], ex_data[wi]});
                if (lg_mod[i] == 3'd0 && lg_addr[i] == 4'd0 && lg_data[i] != 0 &&
                    wi != exp_n - 2) en_early++;
                if (lg_mod[i] != 3'd1 &&
                    !(i + 1 < lg_n && !lg_wr[i+1] && lg_mod[i+1] == lg_mod[i] &&
                      lg_unit[i+1] == lg_unit[i] && lg_chan[i+1] == lg_chan[i] &&
                      lg_addr[i+1] == lg_addr[i])) bad_pair++;
                wi++;
            end else if (lg_mod[i] == 3'd1) out_rd++;
        end
        chk(wi == exp_n, "R9 R10 R12", $sformatf("write count np=%0d nd=%0d", np, nd), wi, exp_n);
        chk(bad_pair == 0, "R8", "read-back pairing", bad_pair, 0);
        chk(out_rd == 0, "R2", "reads of write-only module", out_rd, 0);
        chk(en_early == 0, "R11", "early group enable", en_early, 0);
        chk(done_cnt == 1 && done_cyc == out_cyc + 1, "R7", "done pulse cycle",
            done_cyc, out_cyc + 1);
        chk(!busy && !err, "R8", "idle without error", {busy, err}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !err && !bvalid, "R12", "reset state",
            {busy, done, err, bvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bvalid, "R12", "idle after reset", {busy, bvalid}, 0);

        // Vector table: counts, masks, stall patterns (R10) and mid-run start (R12).
        for (int v = 0; v < NVEC; v++) begin
            build(int'(VECS[v].np), int'(VECS[v].nd), VECS[v].mask);
            launch(int'(VECS[v].np), int'(VECS[v].nd), VECS[v].mask,
                   int'(VECS[v].rmode), VECS[v].mid_start, -1);
            check_run(int'(VECS[v].np), int'(VECS[v].nd));
        end

        // Read-back mismatch on the third read (transmitter range 1, step 5): R8.
        build(0, 0, 4'b0011);
        launch(0, 0, 4'b0011, 0, 1'b0, 2);
        chk(err && err_step == 4'd5, "R8", "error step code", {err, err_step}, {1'b1, 4'd5});
        chk(lg_n == 7 && !busy && done_cnt == 0, "R8", "requests stop after mismatch",
            lg_n, 7);
        repeat (20) @(negedge clk);
        #1;
        chk(err && err_step == 4'd5 && lg_n == 7, "R8", "error held", {err, err_step}, {1'b1, 4'd5});

        // Restart after error clears it and completes normally (R8, R9).
        build(0, 0, 4'b1100);
        launch(0, 0, 4'b1100, 1, 1'b0, -1);
        check_run(0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule